// File: doc/BRIEF.md
# SPI Command Frame Encoder

This block is the command stage of an SPI bus master that reaches a peripheral's registers and DMA engine. On a start pulse it captures an opcode, a 24-bit address, a 32-bit data word, a 24-bit transfer size, a clockless flag and a CRC-enable flag. It packs them into a frame of four to eight body bytes, whose layout depends on the opcode, and shifts the frame out MSB first in SPI mode 0 under a chip select that stays low for the whole frame.

When CRC is enabled, one more byte follows the body. Its upper seven bits hold a CRC7 of every body byte and its lowest bit is zero. The CRC7 uses polynomial x^7+x^3+1 and starts from all ones. It is accumulated serially as the body bits leave the shift register, so the block needs no lookup table. An opcode outside the supported set is refused with a one-cycle reject pulse and produces no bus activity.

Top module: `spi_cmd_framer`

## Requirements
- R1: Accepted opcodes are 0xC1, 0xC2, 0xC3, 0xC4, 0xC5, 0xC6, 0xC7, 0xC8, 0xC9, 0xCA and 0xCF. A start with any other opcode while idle raises `op_reject` for one cycle, on the clock after the start. `cs_n` stays high, `busy` stays low and no SCLK edge occurs.
- R2: Opcode 0xCA sends the opcode followed by address bytes [23:16], [15:8], [7:0]. Opcode 0xC9 sends those same bytes followed by data bytes [31:24] down to [7:0].
- R3: Opcodes 0xC4 and 0xC3 send the opcode, then address[15:8] with bit 7 forced to 1 when `clockless` is high, then address[7:0]. For 0xC4 one 0x00 byte follows. For 0xC3 the four data bytes follow, most significant first.
- R4: Opcodes 0xC1 and 0xC2 send the opcode, three address bytes and size[15:8], size[7:0]. Opcodes 0xC7 and 0xC8 send the opcode, three address bytes and size[23:16], size[15:8], size[7:0].
- R5: Opcodes 0xC5 and 0xC6 send the opcode and three 0x00 bytes. Opcode 0xCF sends the opcode and three 0xFF bytes.
- R6: With `crc_en` high, a trailing byte is sent. Its bits 7..1 are the CRC7 of all body bytes (seed 0x7F, polynomial x^7+x^3+1, bytes processed MSB first) and bit 0 is 0. With `crc_en` low this byte is omitted, so a frame is 4 to 8 bytes without CRC and 5, 7, 8 or 9 bytes with it.
- R7: Bits leave MSB first in mode 0. `sclk` idles low. `mosi` changes only while `sclk` is low and holds steady while `sclk` is high. `mosi` is 0 when idle.
- R8: Each SCLK half period lasts SCLK_HALF clocks. `frame_done` pulses for one cycle, 16*SCLK_HALF*bytes clocks after the clock edge that accepted the start, and `busy` falls on that same edge.
- R9: `cs_n` is low and `busy` is high from the accepting edge until the end of the frame, and neither changes within a frame.
- R10: A start while `busy` is high is ignored: the frame in flight is unchanged, whatever its opcode or fields.
- R11: After reset `cs_n` is 1 and `sclk`, `mosi`, `busy`, `frame_done` and `op_reject` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send one frame |
| opcode | input | 8 | Command opcode |
| addr | input | 24 | Target address |
| wdata | input | 32 | Write data word |
| size | input | 24 | DMA transfer size |
| clockless | input | 1 | Sets bit 7 of the upper address byte of internal accesses |
| crc_en | input | 1 | Append the CRC7 byte |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |
| op_reject | output | 1 | One-cycle pulse for an unsupported opcode |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |

## Verification
The assertions check the bus discipline on every cycle. Chip select tracks busy, SCLK and MOSI sit low when idle, and MOSI stays put while SCLK is high. They also check that the last CRC bit is zero, that the frame length cannot change mid-frame, and that done and reject pulses occur only in the states where they belong. Byte contents and ordering cannot be seen by a property. Neither can the CRC value, the overall frame timing, or the handling of a start that arrives mid-frame. The bench shows these by decoding the serial stream and comparing it with a byte-wise model for every opcode, with CRC both on and off.

// File: rtl/cmdfrm_pkg.sv
package cmdfrm_pkg;

  localparam int BODY_MAX_BYTES  = 8;
  localparam int BODY_W          = BODY_MAX_BYTES * 8;
  localparam int FRAME_MAX_BITS  = (BODY_MAX_BYTES + 1) * 8;
  localparam int BITCNT_W        = $clog2(FRAME_MAX_BITS + 1);

  localparam logic [7:0] OP_DMA_WR  = 8'hC1;
  localparam logic [7:0] OP_DMA_RD  = 8'hC2;
  localparam logic [7:0] OP_INT_WR  = 8'hC3;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_TERM    = 8'hC5;
  localparam logic [7:0] OP_REPEAT  = 8'hC6;
  localparam logic [7:0] OP_XDMA_WR = 8'hC7;
  localparam logic [7:0] OP_XDMA_RD = 8'hC8;
  localparam logic [7:0] OP_SGL_WR  = 8'hC9;
  localparam logic [7:0] OP_SGL_RD  = 8'hCA;
  localparam logic [7:0] OP_RESET   = 8'hCF;

  localparam logic [6:0] CRC7_SEED = 7'h7F;
  localparam logic [6:0] CRC7_POLY = 7'h09;

  // Number of body bytes for an opcode, 0 when the opcode is unsupported.
  function automatic logic [3:0] body_bytes(input logic [7:0] op);
    logic [3:0] n;
    case (op)
      OP_SGL_RD, OP_INT_RD, OP_TERM, OP_REPEAT, OP_RESET: n = 4'd4;
      OP_DMA_WR, OP_DMA_RD:                               n = 4'd6;
      OP_XDMA_WR, OP_XDMA_RD, OP_INT_WR:                  n = 4'd7;
      OP_SGL_WR:                                          n = 4'd8;
      default:                                            n = 4'd0;
    endcase
    return n;
  endfunction

  function automatic logic op_known(input logic [7:0] op);
    return body_bytes(op) != 4'd0;
  endfunction

  // Body packed left-aligned: first byte on the wire in bits [63:56].
  function automatic logic [BODY_W-1:0] body_pack(
    input logic [7:0]  op,
    input logic [23:0] adr,
    input logic [31:0] dat,
    input logic [23:0] sz,
    input logic        clkless
  );
    logic [BODY_W-1:0] f;
    logic [7:0]        ihi;
    f   = '0;
    ihi = {adr[15] | clkless, adr[14:8]};
    case (op)
      OP_SGL_RD:               f[63:32] = {op, adr};
      OP_SGL_WR:               f        = {op, adr, dat};
      OP_INT_RD:               f[63:32] = {op, ihi, adr[7:0], 8'h00};
      OP_INT_WR:               f[63:8]  = {op, ihi, adr[7:0], dat};
      OP_TERM, OP_REPEAT:      f[63:32] = {op, 24'h000000};
      OP_RESET:                f[63:32] = {op, 24'hFFFFFF};
      OP_DMA_WR, OP_DMA_RD:    f[63:16] = {op, adr, sz[15:0]};
      OP_XDMA_WR, OP_XDMA_RD:  f[63:8]  = {op, adr, sz};
      default:                 f        = '0;
    endcase
    return f;
  endfunction

  // One serial CRC7 step, data bit entering MSB first.
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
  endfunction

endpackage

// File: rtl/cmdfrm_crc7.sv
module cmdfrm_crc7
  import cmdfrm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic absorb,
  input  logic drain,
  input  logic bit_in,
  output logic crc_msb
);
  logic [6:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC7_SEED;
    else if (init)   crc_q <= CRC7_SEED;
    else if (absorb) crc_q <= crc7_step(crc_q, bit_in);
    else if (drain)  crc_q <= {crc_q[5:0], 1'b0};
  end

  assign crc_msb = crc_q[6];
endmodule

// File: rtl/cmdfrm_baud.sv
module cmdfrm_baud #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/cmdfrm_shift.sv
module cmdfrm_shift
  import cmdfrm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [BODY_W-1:0]   body,
  input  logic [BITCNT_W-1:0] body_bits,
  input  logic [BITCNT_W-1:0] frame_bits,
  input  logic                tick,
  input  logic                crc_msb,
  output logic                run,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  output logic                done,
  output logic                absorb,
  output logic                drain,
  output logic                body_bit,
  output logic                last_bit,
  output logic                crc_on,
  output logic [BITCNT_W-1:0] bit_idx,
  output logic [BITCNT_W-1:0] frame_bits_q
);
  logic [BODY_W-1:0]   sh_q;
  logic [BITCNT_W-1:0] body_bits_q;
  logic                in_crc;
  logic                fall;

  assign in_crc   = bit_idx >= body_bits_q;
  assign last_bit = bit_idx == frame_bits_q - 1'b1;
  assign fall     = run && tick && sclk;
  assign absorb   = fall && !last_bit && !in_crc;
  assign drain    = fall && !last_bit && in_crc;
  assign body_bit = sh_q[BODY_W-1];
  assign crc_on   = frame_bits_q != body_bits_q;
  assign mosi     = run && (in_crc ? crc_msb : sh_q[BODY_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run          <= 1'b0;
      sclk         <= 1'b0;
      cs_n         <= 1'b1;
      done         <= 1'b0;
      sh_q         <= '0;
      bit_idx      <= '0;
      body_bits_q  <= '0;
      frame_bits_q <= '0;
    end else begin
      done <= 1'b0;
      if (load && !run) begin
        run          <= 1'b1;
        cs_n         <= 1'b0;
        sclk         <= 1'b0;
        sh_q         <= body;
        bit_idx      <= '0;
        body_bits_q  <= body_bits;
        frame_bits_q <= frame_bits;
      end else if (run && tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (last_bit) begin
            run  <= 1'b0;
            cs_n <= 1'b1;
            done <= 1'b1;
          end else begin
            sh_q    <= {sh_q[BODY_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
  import cmdfrm_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [23:0] addr,
  input  logic [31:0] wdata,
  input  logic [23:0] size,
  input  logic        clockless,
  input  logic        crc_en,
  output logic        busy,
  output logic        frame_done,
  output logic        op_reject,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi
);
  logic                accept;
  logic                reject_d;
  logic                op_reject_q;
  logic [BODY_W-1:0]   body;
  logic [BITCNT_W-1:0] body_bits;
  logic [BITCNT_W-1:0] frame_bits;
  logic                tick;
  logic                crc_msb;
  logic                ser_run;
  logic                ser_absorb;
  logic                ser_drain;
  logic                ser_body_bit;
  logic                ser_last_bit;
  logic                ser_crc_on;
  logic [BITCNT_W-1:0] ser_bit_idx;
  logic [BITCNT_W-1:0] ser_frame_bits;

  assign accept     = start && !ser_run && op_known(opcode);
  assign reject_d   = start && !ser_run && !op_known(opcode);
  assign body       = body_pack(opcode, addr, wdata, size, clockless);
  assign body_bits  = BITCNT_W'({body_bytes(opcode), 3'b000});
  assign frame_bits = body_bits + (crc_en ? BITCNT_W'(8) : BITCNT_W'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_reject_q <= 1'b0;
    else        op_reject_q <= reject_d;
  end

  cmdfrm_baud #(.HALF(SCLK_HALF)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ser_run),
    .tick (tick)
  );

  cmdfrm_crc7 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (accept),
    .absorb (ser_absorb),
    .drain  (ser_drain),
    .bit_in (ser_body_bit),
    .crc_msb(crc_msb)
  );

  cmdfrm_shift u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .body        (body),
    .body_bits   (body_bits),
    .frame_bits  (frame_bits),
    .tick        (tick),
    .crc_msb     (crc_msb),
    .run         (ser_run),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .mosi        (mosi),
    .done        (frame_done),
    .absorb      (ser_absorb),
    .drain       (ser_drain),
    .body_bit    (ser_body_bit),
    .last_bit    (ser_last_bit),
    .crc_on      (ser_crc_on),
    .bit_idx     (ser_bit_idx),
    .frame_bits_q(ser_frame_bits)
  );

  assign busy      = ser_run;
  assign op_reject = op_reject_q;
endmodule

// File: rtl/cmdfrm_chk.sv
module cmdfrm_chk
  import cmdfrm_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                frame_done,
  input logic                op_reject,
  input logic                sclk,
  input logic                cs_n,
  input logic                mosi,
  input logic                ser_last_bit,
  input logic                ser_crc_on,
  input logic [BITCNT_W-1:0] ser_bit_idx,
  input logic [BITCNT_W-1:0] ser_frame_bits
);
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject |-> (!busy && cs_n && !sclk)); // R1
  AST_CRC_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ser_last_bit && ser_crc_on) |-> !mosi); // R6
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !mosi)); // R7
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sclk && $past(sclk)) |-> $stable(mosi)); // R7
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!busy && $past(busy))); // R8
  AST_CS_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n == !busy); // R9
  AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ser_bit_idx < ser_frame_bits)); // R9
  AST_FRAME_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ser_frame_bits)); // R10
endmodule

bind spi_cmd_framer cmdfrm_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .frame_done    (frame_done),
  .op_reject     (op_reject),
  .sclk          (sclk),
  .cs_n          (cs_n),
  .mosi          (mosi),
  .ser_last_bit  (ser_last_bit),
  .ser_crc_on    (ser_crc_on),
  .ser_bit_idx   (ser_bit_idx),
  .ser_frame_bits(ser_frame_bits)
);

// File: tb/test_spi_cmd_framer.sv
module test_spi_cmd_framer;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [23:0] size = '0;
  logic        clockless = 1'b0;
  logic        crc_en = 1'b0;
  logic        busy, frame_done, op_reject, sclk, cs_n, mosi;

  int checks = 0;
  int fails  = 0;

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] acc = 8'h00;
  int         nbits = 0;
  logic       prev_sclk = 1'b0;
  logic       prev_mosi = 1'b0;
  int         mode_err = 0;
  int         edge_cnt = 0;

  spi_cmd_framer #(.SCLK_HALF(HALF)) i_spi_cmd_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
    .wdata(wdata), .size(size), .clockless(clockless), .crc_en(crc_en),
    .busy(busy), .frame_done(frame_done), .op_reject(op_reject),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Serial capture: a bit is taken on every rising SCLK seen between edges.
  always @(negedge clk) begin
    if (sclk && !prev_sclk) begin
      acc = {acc[6:0], mosi};
      nbits++;
      edge_cnt++;
      if (nbits == 8) begin
        got_q.push_back(acc);
        nbits = 0;
      end
    end
    if (sclk && prev_sclk && (mosi !== prev_mosi)) mode_err++;
    if (!busy && (sclk || mosi)) mode_err++;
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Byte-wise CRC7 reference: table entry computed by long division.
  function automatic logic [7:0] tbl(input logic [7:0] idx);
    logic [7:0] r;
    r = idx;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h12) : (r << 1);
    return r >> 1;
  endfunction

  task automatic build_expected(input logic [7:0] op, input logic [23:0] a,
                                input logic [31:0] d, input logic [23:0] s,
                                input bit cl, input bit ce);
    logic [7:0] c;
    exp_q.delete();
    exp_q.push_back(op);
    case (op)
      8'hCA: begin exp_q.push_back(a[23:16]); exp_q.push_back(a[15:8]); exp_q.push_back(a[7:0]); end
      8'hC9: begin
        exp_q.push_back(a[23:16]); exp_q.push_back(a[15:8]); exp_q.push_back(a[7:0]);
        for (int k = 3; k >= 0; k--) exp_q.push_back(d[k*8 +: 8]);
      end
      8'hC4, 8'hC3: begin
        exp_q.push_back(a[15:8] | (cl ? 8'h80 : 8'h00));
        exp_q.push_back(a[7:0]);
        if (op == 8'hC4) exp_q.push_back(8'h00);
        else for (int k = 3; k >= 0; k--) exp_q.push_back(d[k*8 +: 8]);
      end
      8'hC5, 8'hC6: repeat (3) exp_q.push_back(8'h00);
      8'hCF:        repeat (3) exp_q.push_back(8'hFF);
      8'hC1, 8'hC2, 8'hC7, 8'hC8: begin
        exp_q.push_back(a[23:16]); exp_q.push_back(a[15:8]); exp_q.push_back(a[7:0]);
        if (op == 8'hC7 || op == 8'hC8) exp_q.push_back(s[23:16]);
        exp_q.push_back(s[15:8]); exp_q.push_back(s[7:0]);
      end
      default: ;
    endcase
    if (ce) begin
      c = 8'h7F;
      foreach (exp_q[k]) c = tbl({c[6:0], 1'b0} ^ exp_q[k]);
      exp_q.push_back({c[6:0], 1'b0});
    end
  endtask

  task automatic run_frame(input logic [7:0] op, input logic [23:0] a,
                           input logic [31:0] d, input logic [23:0] s,
                           input bit cl, input bit ce, input string req,
                           input bit poke);
    int n;
    int bad_cycle;
    int first_bad;
    build_expected(op, a, d, s, cl, ce);
    got_q.delete();
    nbits = 0;
    mode_err = 0;
    @(negedge clk);
    opcode = op; addr = a; wdata = d; size = s; clockless = cl; crc_en = ce;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    bad_cycle = 0;
    while (!frame_done && n < 5000) begin
      if (busy !== 1'b1 || cs_n !== 1'b0) bad_cycle++;
      if (poke && n == 10) begin
        opcode = 8'hC9; addr = 24'h5A5A5A; wdata = 32'h0F0F0F0F; crc_en = ~ce;
        start = 1'b1;
      end
      if (poke && n == 11) start = 1'b0;
      @(negedge clk);
      n++;
    end
    check(busy == 1'b0 && cs_n == 1'b1, "R8", "busy/cs_n after done", {busy, cs_n}, 2'b01);
    check(bad_cycle == 0, "R9", "cycles with cs_n high or busy low in frame", bad_cycle, 0);
    check(n - 1 == 16 * HALF * exp_q.size(), "R8", "clocks to done", n - 1,
          16 * HALF * exp_q.size());
    check(got_q.size() == exp_q.size() && nbits == 0, "R6", "frame length bytes",
          got_q.size(), exp_q.size());
    first_bad = -1;
    for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
      if (got_q[k] !== exp_q[k] && first_bad < 0) first_bad = k;
    if (first_bad >= 0)
      check(1'b0, req, $sformatf("frame byte %0d", first_bad), got_q[first_bad], exp_q[first_bad]);
    else
      check(1'b1, req, "frame bytes", 0, 0);
    check(mode_err == 0, "R7", "mosi changed while sclk high / idle lines", mode_err, 0);
    @(negedge clk);
    check(frame_done == 1'b0, "R8", "done pulse width", frame_done, 0);
  endtask

  task automatic try_bad(input logic [7:0] op);
    int e0;
    e0 = edge_cnt;
    @(negedge clk);
    opcode = op; crc_en = 1'b1; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(op_reject == 1'b1 && busy == 1'b0 && cs_n == 1'b1, "R1",
          "reject pulse, no frame", {op_reject, busy, cs_n}, 3'b101);
    @(negedge clk);
    check(op_reject == 1'b0, "R1", "reject pulse width", op_reject, 0);
    repeat (20) @(negedge clk);
    check(edge_cnt == e0 && cs_n == 1'b1, "R1", "sclk edges after reject", edge_cnt - e0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({cs_n, sclk, mosi, busy, frame_done, op_reject} == 6'b100000, "R11",
          "reset outputs", {cs_n, sclk, mosi, busy, frame_done, op_reject}, 6'b100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({cs_n, sclk, busy} == 3'b100, "R11", "idle after reset", {cs_n, sclk, busy}, 3'b100);

    run_frame(8'hCA, 24'h123456, 32'h0, 24'h0, 1'b0, 1'b1, "R2", 1'b0);
    run_frame(8'hCA, 24'hFEDCBA, 32'h0, 24'h0, 1'b0, 1'b0, "R2", 1'b0);
    run_frame(8'hC9, 24'h00E824, 32'hDEADBEEF, 24'h0, 1'b0, 1'b1, "R2", 1'b0);
    run_frame(8'hC9, 24'h001000, 32'h01234567, 24'h0, 1'b0, 1'b0, "R2", 1'b0);
    run_frame(8'hC4, 24'h000024, 32'h0, 24'h0, 1'b1, 1'b1, "R3", 1'b0);
    run_frame(8'hC4, 24'h0012A5, 32'h0, 24'h0, 1'b0, 1'b1, "R3", 1'b0);
    run_frame(8'hC3, 24'h000030, 32'hCAFEF00D, 24'h0, 1'b1, 1'b0, "R3", 1'b0);
    run_frame(8'hC3, 24'h00FF30, 32'h89ABCDEF, 24'h0, 1'b0, 1'b1, "R3", 1'b0);
    run_frame(8'hC1, 24'hABCDEF, 32'h0, 24'h001234, 1'b0, 1'b1, "R4", 1'b0);
    run_frame(8'hC2, 24'h010203, 32'h0, 24'hFF8001, 1'b0, 1'b0, "R4", 1'b0);
    run_frame(8'hC7, 24'h3C0000, 32'h0, 24'hABCDEF, 1'b0, 1'b1, "R4", 1'b0);
    run_frame(8'hC8, 24'h000001, 32'h0, 24'h020000, 1'b1, 1'b0, "R4", 1'b0);
    run_frame(8'hC5, 24'h777777, 32'hFFFFFFFF, 24'hFFFFFF, 1'b1, 1'b1, "R5", 1'b0);
    run_frame(8'hC6, 24'h0, 32'h0, 24'h0, 1'b0, 1'b0, "R5", 1'b0);
    run_frame(8'hCF, 24'h0, 32'h0, 24'h0, 1'b0, 1'b1, "R5", 1'b0);
    run_frame(8'hCF, 24'h0, 32'h0, 24'h0, 1'b0, 1'b0, "R5", 1'b0);

    try_bad(8'hC0);
    try_bad(8'hCB);
    try_bad(8'h00);

    run_frame(8'hCA, 24'h13579B, 32'h0, 24'h0, 1'b0, 1'b1, "R10", 1'b1);
    run_frame(8'hC4, 24'h000011, 32'h0, 24'h0, 1'b1, 1'b0, "R10", 1'b1);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule